// File: doc/BRIEF.md
# Branch Condition Evaluator

This combinational unit decides whether a conditional control transfer is taken. It reads a 4-bit condition code, five status flags (carry, zero, sign, overflow, parity), an operation select and a count register value. It returns a single taken bit together with the count value the register should hold afterwards.

Three operations share the path. A flag-tested branch picks one of sixteen conditions, covering unsigned ordering, signed ordering, equality and single-flag tests. A count-zero test is taken when the count is zero and leaves the count alone. A loop step decrements the count and is taken only when the decremented value is nonzero. A width select decides whether the count behaves as a 16-bit or a 32-bit register. In 16-bit mode the upper half is passed through untouched. The unit never writes the flags. Target address generation and fetch belong to the surrounding pipeline.

Top module: `branch_cond_eval`

## Requirements
- R1: For op_i=0, every odd cond_i value is taken exactly when the even value one below it would not be taken for the same flags, because bit 0 of the code inverts the base test.
- R2: cond_i=4 is taken when zf_i=1, and cond_i=5 is taken when zf_i=0.
- R3: Unsigned ordering: cond_i=2 is taken when cf_i=1, 3 when cf_i=0, 6 when cf_i=1 or zf_i=1, and 7 when cf_i=0 and zf_i=0.
- R4: Signed ordering: cond_i=12 is taken when sf_i differs from of_i, 13 when sf_i equals of_i, 14 when zf_i=1 or sf_i differs from of_i, and 15 when zf_i=0 and sf_i equals of_i.
- R5: Single-flag tests: cond_i=0 is taken when of_i=1 and 1 when of_i=0. cond_i=8 is taken when sf_i=1 and 9 when sf_i=0. cond_i=10 is taken when pf_i=1 and 11 when pf_i=0.
- R6: op_i encodes 0 = flag-tested branch, 1 = count-zero test, 2 = loop step and 3 = reserved. The reserved value is never taken and returns count_i unchanged on count_o.
- R7: For op_i=1, taken_o is 1 exactly when the selected-width count is zero, and count_o equals count_i.
- R8: For op_i=2, count_o is the selected-width count minus one, wrapping from zero to all ones. taken_o is 1 exactly when that new value is nonzero.
- R9: With wide_i=0, only bits 15:0 are decremented and tested, and bits 31:16 of count_o equal those of count_i. With wide_i=1, all 32 bits are used.
- R10: For op_i other than 2, count_o equals count_i. The flags have no effect on the taken_o or count_o results of op_i=1 or op_i=2.
- R11: For op_i=0, count_i and wide_i have no effect on taken_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 0 flag branch, 1 count-zero, 2 loop step, 3 reserved |
| cond_i | input | 4 | Condition code for flag branch |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag (1 = even count of ones) |
| wide_i | input | 1 | Count width: 1 = 32 bits, 0 = 16 bits |
| count_i | input | 32 | Current count register value |
| taken_o | output | 1 | Branch taken |
| count_o | output | 32 | Count register value after the operation |

## Verification
The bench builds the unit with its defaults: a 32-bit count and a 16-bit narrow mode. These values put both width modes within reach. In narrow mode, a borrow out of bit 15 has to stop at the half boundary while the upper bits hold distinct patterns, and both modes wrap from zero to all ones. Every condition code is swept against all 32 flag combinations.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [1:0] {
    OP_FLAG = 2'd0,
    OP_CNTZ = 2'd1,
    OP_LOOP = 2'd2,
    OP_RSVD = 2'd3
  } bce_op_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic of;
    logic pf;
  } bce_flags_t;
endpackage

// File: rtl/bce_flag_eval.sv
module bce_flag_eval
  import bce_pkg::*;
(
  input  logic [3:0] cond_i,
  input  bce_flags_t flags_i,
  output logic       taken_o
);
  logic base;
  logic lt;

  assign lt = flags_i.sf ^ flags_i.of;

  // upper three bits pick the test, bit 0 inverts it
  always_comb begin
    unique case (cond_i[3:1])
      3'd0: base = flags_i.of;
      3'd1: base = flags_i.cf;
      3'd2: base = flags_i.zf;
      3'd3: base = flags_i.cf | flags_i.zf;
      3'd4: base = flags_i.sf;
      3'd5: base = flags_i.pf;
      3'd6: base = lt;
      default: base = flags_i.zf | lt;
    endcase
  end

  assign taken_o = base ^ cond_i[0];
endmodule

// File: rtl/bce_count_unit.sv
module bce_count_unit #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             wide_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] dec_o,
  output logic             cur_zero_o,
  output logic             dec_zero_o
);
  logic [CNT_W-1:0]    dec_full;
  logic [NARROW_W-1:0] dec_lo;
  logic [CNT_W-1:0]    dec_narrow;

  assign dec_full = count_i - 1'b1;
  assign dec_lo   = count_i[NARROW_W-1:0] - 1'b1;

  generate
    if (NARROW_W < CNT_W) begin : g_split
      assign dec_narrow = {count_i[CNT_W-1:NARROW_W], dec_lo};
    end else begin : g_same
      assign dec_narrow = dec_lo;
    end
  endgenerate

  assign dec_o      = wide_i ? dec_full : dec_narrow;
  assign cur_zero_o = wide_i ? (count_i == '0) : (count_i[NARROW_W-1:0] == '0);
  assign dec_zero_o = wide_i ? (dec_full == '0) : (dec_lo == '0);
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [1:0]       op_i,
  input  logic [3:0]       cond_i,
  input  logic             cf_i,
  input  logic             zf_i,
  input  logic             sf_i,
  input  logic             of_i,
  input  logic             pf_i,
  input  logic             wide_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             taken_o,
  output logic [CNT_W-1:0] count_o
);
  bce_flags_t       flags;
  bce_op_e          op;
  logic             flag_taken;
  logic [CNT_W-1:0] cnt_dec;
  logic             cnt_zero;
  logic             dec_zero;

  assign flags = '{cf: cf_i, zf: zf_i, sf: sf_i, of: of_i, pf: pf_i};
  assign op    = bce_op_e'(op_i);

  bce_flag_eval u_flag (
    .cond_i (cond_i),
    .flags_i(flags),
    .taken_o(flag_taken)
  );

  bce_count_unit #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .wide_i    (wide_i),
    .count_i   (count_i),
    .dec_o     (cnt_dec),
    .cur_zero_o(cnt_zero),
    .dec_zero_o(dec_zero)
  );

  always_comb begin
    taken_o = 1'b0;
    count_o = count_i;
    unique case (op)
      OP_FLAG: taken_o = flag_taken;
      OP_CNTZ: taken_o = cnt_zero;
      OP_LOOP: begin
        taken_o = ~dec_zero;
        count_o = cnt_dec;
      end
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic [1:0]       op_i,
  input logic             wide_i,
  input logic [CNT_W-1:0] count_i,
  input logic             taken_o,
  input logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] sel_mask;
  logic             known;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) sel_mask[i] = wide_i | (i < NARROW_W);
  end

  assign known = !$isunknown({op_i, wide_i, count_i, taken_o, count_o});

  always_comb begin
    if (known) begin
      if (op_i != 2'd2)
        AST_COUNT_HOLD: assert (count_o == count_i) else $error("count changed"); // R10
      if (op_i == 2'd2)
        AST_LOOP_DEC: assert (((count_o + 1'b1) & sel_mask) == (count_i & sel_mask))
          else $error("loop decrement"); // R8
      if (op_i == 2'd2)
        AST_LOOP_TAKEN: assert (taken_o == ((count_o & sel_mask) != '0))
          else $error("loop taken"); // R8
      if (op_i == 2'd2)
        AST_UPPER_KEEP: assert ((count_o & ~sel_mask) == (count_i & ~sel_mask))
          else $error("upper bits"); // R9
      if (op_i == 2'd1)
        AST_CNTZ_TAKEN: assert (taken_o == ((count_i & sel_mask) == '0))
          else $error("count-zero"); // R7
      if (op_i == 2'd3)
        AST_RSVD_IDLE: assert (!taken_o) else $error("reserved taken"); // R6
    end
  end
endmodule

bind branch_cond_eval bce_checker #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .op_i   (op_i),
  .wide_i (wide_i),
  .count_i(count_i),
  .taken_o(taken_o),
  .count_o(count_o)
);

// File: tb/sim_branch_cond_eval.sv
`timescale 1ns/1ps
module sim_branch_cond_eval;
  logic        clk = 1'b0;
  logic [1:0]  op;
  logic [3:0]  cond;
  logic        cf, zf, sf, of, pf;
  logic        wide;
  logic [31:0] count;
  logic        taken;
  logic [31:0] count_q;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  branch_cond_eval u0 (
    .op_i(op), .cond_i(cond), .cf_i(cf), .zf_i(zf), .sf_i(sf), .of_i(of),
    .pf_i(pf), .wide_i(wide), .count_i(count), .taken_o(taken), .count_o(count_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [3:0] c, input logic [4:0] f,
                       input logic w, input logic [31:0] n);
    @(posedge clk);
    op = o; cond = c; {cf, zf, sf, of, pf} = f; wide = w; count = n;
    @(negedge clk);
  endtask

  // reference from the requirement text; f = {cf,zf,sf,of,pf}
  function automatic logic ref_cond(input logic [3:0] c, input logic [4:0] f);
    logic c_, z_, s_, o_, p_;
    {c_, z_, s_, o_, p_} = f;
    case (c)
      4'd0:  return o_;
      4'd1:  return !o_;
      4'd2:  return c_;
      4'd3:  return !c_;
      4'd4:  return z_;
      4'd5:  return !z_;
      4'd6:  return c_ || z_;
      4'd7:  return !c_ && !z_;
      4'd8:  return s_;
      4'd9:  return !s_;
      4'd10: return p_;
      4'd11: return !p_;
      4'd12: return s_ != o_;
      4'd13: return s_ == o_;
      4'd14: return z_ || (s_ != o_);
      default: return !z_ && (s_ == o_);
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c == 4 || c == 5) return "R2";
    if (c == 2 || c == 3 || c == 6 || c == 7) return "R3";
    if (c >= 12) return "R4";
    return "R5";
  endfunction

  task automatic t_idle;
    apply(2'd3, 4'd0, 5'h1f, 1'b1, 32'h1234_5678);
    chk("R6 reserved taken", {31'd0, taken}, 32'd0);
    chk("R6 reserved count", count_q, 32'h1234_5678);
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        apply(2'd0, 4'(c), 5'(f), f[0], 32'(f * 977));
        chk(req_of(4'(c)), {31'd0, taken}, {31'd0, ref_cond(4'(c), 5'(f))});
        if (c[0]) chk("R1 pair", {31'd0, taken}, {31'd0, !ref_cond(4'(c - 1), 5'(f))});
      end
    end
  endtask

  task automatic t_ignore_count;
    apply(2'd0, 4'd4, 5'b01000, 1'b0, 32'h0);
    chk("R11 count zero", {31'd0, taken}, 32'd1);
    apply(2'd0, 4'd4, 5'b01000, 1'b1, 32'hffff_ffff);
    chk("R11 count ones", {31'd0, taken}, 32'd1);
    chk("R10 flag op count", count_q, 32'hffff_ffff);
  endtask

  task automatic t_count_zero;
    apply(2'd1, 4'd0, 5'h00, 1'b1, 32'h0);
    chk("R7 zero taken", {31'd0, taken}, 32'd1);
    chk("R7 count held", count_q, 32'h0);
    apply(2'd1, 4'd0, 5'h1f, 1'b1, 32'h0001_0000);
    chk("R7 wide nonzero", {31'd0, taken}, 32'd0);
    apply(2'd1, 4'd0, 5'h1f, 1'b0, 32'h0001_0000);
    chk("R9 narrow low zero", {31'd0, taken}, 32'd1);
    chk("R7 count held narrow", count_q, 32'h0001_0000);
    apply(2'd1, 4'd0, 5'h00, 1'b0, 32'h0000_0001);
    chk("R7 narrow nonzero", {31'd0, taken}, 32'd0);
  endtask

  task automatic t_loop;
    apply(2'd2, 4'd0, 5'h00, 1'b1, 32'd5);
    chk("R8 dec", count_q, 32'd4);
    chk("R8 taken", {31'd0, taken}, 32'd1);
    apply(2'd2, 4'd7, 5'h1f, 1'b1, 32'd1);
    chk("R8 to zero", count_q, 32'd0);
    chk("R8 not taken", {31'd0, taken}, 32'd0);
    apply(2'd2, 4'd0, 5'h00, 1'b1, 32'd0);
    chk("R8 wrap", count_q, 32'hffff_ffff);
    chk("R8 wrap taken", {31'd0, taken}, 32'd1);
    apply(2'd2, 4'd0, 5'h00, 1'b1, 32'h0001_0000);
    chk("R9 wide borrow", count_q, 32'h0000_ffff);
  endtask

  task automatic t_narrow;
    apply(2'd2, 4'd0, 5'h00, 1'b0, 32'habcd_0000);
    chk("R9 narrow wrap", count_q, 32'habcd_ffff);
    chk("R9 narrow wrap taken", {31'd0, taken}, 32'd1);
    apply(2'd2, 4'd0, 5'h00, 1'b0, 32'h5a5a_0001);
    chk("R9 narrow to zero", count_q, 32'h5a5a_0000);
    chk("R9 upper ignored", {31'd0, taken}, 32'd0);
    apply(2'd2, 4'd0, 5'h00, 1'b0, 32'h0000_1000);
    chk("R9 narrow dec", count_q, 32'h0000_0fff);
  endtask

  task automatic t_flags_ignored;
    for (int f = 0; f < 32; f += 7) begin
      apply(2'd2, 4'(f), 5'(f), 1'b1, 32'd3);
      chk("R10 loop flags", {count_q[30:0], taken}, {31'd2, 1'b1});
      apply(2'd1, 4'(f), 5'(f), 1'b1, 32'd3);
      chk("R10 cntz flags", {count_q[30:0], taken}, {31'd3, 1'b0});
    end
  endtask

  initial begin
    op = 2'd3; cond = '0; {cf, zf, sf, of, pf} = '0; wide = 1'b1; count = '0;
    t_idle;
    t_sweep;
    t_ignore_count;
    t_count_zero;
    t_loop;
    t_narrow;
    t_flags_ignored;
    t_idle;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule